// File: doc/BRIEF.md
# Serial-to-Parallel Output Expander with Storage Latch

This block turns a serial bit stream into eight parallel outputs. Bits enter a shift chain on the rising edge of a shift clock. A rising edge of a separate storage clock copies the whole chain into a storage register at once. The parallel pins are driven only from that storage register. Because of this, the pins stay steady while the next word is being shifted in, and all eight change together when the word is committed.

An active-low output enable puts the parallel pins into high impedance. An asynchronous active-low clear empties the shift chain and has no effect on the storage register. A serial pin carries the last stage of the chain and is not gated by the output enable. Several instances can therefore be chained, each one feeding the data input of the next, with all of them sharing the clocks.

Top module: `ser_par_expander`

## Requirements
- R1: The parallel outputs change only on a storage-clock rising edge. Shift-clock edges, serial data and clear leave the enabled parallel value unchanged.
- R2: On each shift-clock rising edge, stage 0 takes `ser_in` and stage k takes the old stage k-1. Parallel bit i shows stage i after a transfer, so eight bits shifted in most-significant first appear as the same byte.
- R3: While the shift clock has no rising edge, toggling `ser_in` does not change the shift chain, as seen on `ser_out` and on a later transfer.
- R4: While `clr_n` is low, every shift stage reads zero, even if shift-clock edges arrive with `ser_in` high.
- R5: A storage-clock rising edge copies all eight shift stages into the storage register. Between such edges the storage register holds its value.
- R6: With `oe_n` high, all eight `par_q` bits are high impedance. With `oe_n` low, they show the storage register.
- R7: `ser_out` always equals shift stage 7, whatever the value of `oe_n`.
- R8: A clear does not alter the storage register. A storage-clock edge after a clear transfers 0x00.
- R9: When both clocks rise together, the storage register takes the shift-chain value from just before that edge.
- R10: Releasing `clr_n` needs no clock. The first shift-clock edge after the release shifts in `ser_in` normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data, sampled on the shift-clock rising edge |
| shift_clk | input | 1 | Shift-chain clock, rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of the shift chain only |
| store_clk | input | 1 | Storage-register clock, rising edge |
| oe_n | input | 1 | Active-low enable of the parallel pins |
| par_q | output | 8 | Three-state parallel outputs from the storage register |
| ser_out | output | 1 | Cascade output, last shift stage |

## Verification
On every clock edge, the assertions check the shift recurrence, the cascade pin's one-stage delay, the transfer on each storage edge, and that the storage register holds across shift edges that have no storage edge between them. The bench scenarios are needed for the rest: the asynchronous clear winning over live shift edges, clear release without a clock, coincident clock edges, and the high-impedance state. The bench observes high impedance through a pulled-up net, where a floating pin reads as 0xFF.

// File: rtl/xpd_pkg.sv
// Package: shared constants for the serial-to-parallel expander.
// Assumes: consumers size their vectors from STAGES_DEF unless overridden.
package xpd_pkg;
    localparam int STAGES_DEF = 8;
    typedef enum logic {OUT_DRIVEN = 1'b0, OUT_FLOATING = 1'b1} oe_state_e;
endpackage

// File: rtl/xpd_shift_chain.sv
// Module: serial shift chain with asynchronous active-low clear.
// Assumes: rising-edge shift clock; the clear wins over any clock edge.
module xpd_shift_chain #(
    parameter int W = xpd_pkg::STAGES_DEF
) (
    input  logic         shift_clk,
    input  logic         clr_n,
    input  logic         din,
    output logic [W-1:0] stages,
    output logic         tail
);
    logic [W-1:0] feed;

    // Purpose: each stage is fed by its predecessor, stage 0 by the serial input.
    assign feed = {stages[W-2:0], din};

    for (genvar i = 0; i < W; i++) begin : g_stage
        // Purpose: one flop of the chain, emptied asynchronously by the clear.
        always_ff @(posedge shift_clk or negedge clr_n) begin
            if (!clr_n) stages[i] <= 1'b0;
            else        stages[i] <= feed[i];
        end
    end

    // Purpose: cascade tap from the last stage.
    assign tail = stages[W-1];
endmodule

// File: rtl/xpd_hold_reg.sv
// Module: storage register loaded from the shift chain on its own clock.
// Assumes: no reset; contents are undefined until the first load.
module xpd_hold_reg #(
    parameter int W = xpd_pkg::STAGES_DEF
) (
    input  logic         store_clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: capture the whole chain on a storage-clock rising edge.
    always_ff @(posedge store_clk) begin
        q <= d;
    end
endmodule

// File: rtl/xpd_tri_drv.sv
// Module: per-bit three-state driver for the parallel pins.
// Assumes: the enable is active-low and common to all bits.
module xpd_tri_drv #(
    parameter int W = xpd_pkg::STAGES_DEF
) (
    input  logic         oe_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] pin
);
    import xpd_pkg::*;
    oe_state_e mode;

    // Purpose: name the enable state.
    assign mode = oe_state_e'(oe_n);

    for (genvar i = 0; i < W; i++) begin : g_pin
        // Purpose: float the pin when disabled, otherwise drive the stored bit.
        assign pin[i] = (mode == OUT_FLOATING) ? 1'bz : d[i];
    end
endmodule

// File: rtl/ser_par_expander.sv
// Module: top of the serial-to-parallel expander.
// Assumes: two independent rising-edge clocks; the clear touches only the
// shift chain; the cascade pin bypasses the storage and the enable.
module ser_par_expander (
    input  logic       ser_in,
    input  logic       shift_clk,
    input  logic       clr_n,
    input  logic       store_clk,
    input  logic       oe_n,
    output logic [7:0] par_q,
    output logic       ser_out
);
    localparam int W = xpd_pkg::STAGES_DEF;

    logic [W-1:0] sr_q;
    logic [W-1:0] st_q;

    // Purpose: shift chain and cascade tap.
    xpd_shift_chain #(.W(W)) u_chain (
        .shift_clk(shift_clk),
        .clr_n    (clr_n),
        .din      (ser_in),
        .stages   (sr_q),
        .tail     (ser_out)
    );

    // Purpose: storage register between the chain and the pins.
    xpd_hold_reg #(.W(W)) u_hold (
        .store_clk(store_clk),
        .d        (sr_q),
        .q        (st_q)
    );

    // Purpose: three-state pin drivers.
    xpd_tri_drv #(.W(W)) u_drv (
        .oe_n(oe_n),
        .d   (st_q),
        .pin (par_q)
    );
endmodule

// File: rtl/xpd_checker.sv
// Module: property checker for the expander, bound to the top.
// Assumes: the clear is the only reset; history counters restart on it.
module xpd_checker #(
    parameter int W = 8
) (
    input logic         shift_clk,
    input logic         store_clk,
    input logic         clr_n,
    input logic         ser_in,
    input logic         ser_out,
    input logic [W-1:0] sr_q,
    input logic [W-1:0] st_q
);
    logic [1:0] sh_edges;
    logic       sh_seen = 1'b0;
    logic       st_seen = 1'b0;
    logic [7:0] st_edges = 8'd0;

    // Purpose: count shift edges since the last clear, saturating at two.
    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n)              sh_edges <= 2'd0;
        else if (sh_edges != 2'd2) sh_edges <= sh_edges + 2'd1;
    end

    // Purpose: note that a shift edge has occurred at least once.
    always_ff @(posedge shift_clk) sh_seen <= 1'b1;

    // Purpose: note storage edges and count them.
    always_ff @(posedge store_clk) begin
        st_seen  <= 1'b1;
        st_edges <= st_edges + 8'd1;
    end

    // R2
    shift_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
        (sh_edges == 2'd2) |-> (sr_q == {$past(sr_q[W-2:0]), $past(ser_in)}));

    // R7
    cascade_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
        (sh_edges == 2'd2) |-> (ser_out == $past(sr_q[W-2])));

    // R5
    transfer_chk: assert property (@(posedge store_clk) disable iff (!clr_n)
        st_seen |-> (st_q == $past(sr_q)));

    // R1
    hold_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
        (sh_seen && $stable(st_edges)) |-> $stable(st_q));
endmodule

bind ser_par_expander xpd_checker #(.W(8)) u_chk (
    .shift_clk(shift_clk),
    .store_clk(store_clk),
    .clr_n    (clr_n),
    .ser_in   (ser_in),
    .ser_out  (ser_out),
    .sr_q     (sr_q),
    .st_q     (st_q)
);

// File: tb/sim_ser_par_expander.sv
module sim_ser_par_expander;
    typedef struct {
        string      tag;
        logic [7:0] par;
        logic       ser;
        bit         chk_par;
    } exp_t;

    logic clk = 1'b0;
    logic ser_in = 1'b0, shift_clk = 1'b0, clr_n = 1'b1, store_clk = 1'b0, oe_n = 1'b1;
    tri1  [7:0] par_bus;
    logic ser_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;
    exp_t q[$];
    logic [7:0] m_sr = 8'h00;
    logic [7:0] m_st = 8'h00;

    ser_par_expander u0 (
        .ser_in(ser_in), .shift_clk(shift_clk), .clr_n(clr_n),
        .store_clk(store_clk), .oe_n(oe_n), .par_q(par_bus), .ser_out(ser_out)
    );

    always #5 clk = ~clk;

    // monitor: pop expected items and compare at the rising bench edge
    always @(posedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.ser !== ser_out) begin
                fails++;
                $display("FAIL %s ser_out actual=%b expected=%b", e.tag, ser_out, e.ser);
            end else if (e.chk_par && (e.par !== par_bus)) begin
                fails++;
                $display("FAIL %s par_q actual=%h expected=%h", e.tag, par_bus, e.par);
            end
        end
    end

    task automatic expect_now(input string tag, input bit chk_par);
        exp_t e;
        e.tag = tag;
        e.par = oe_n ? 8'hFF : m_st;
        e.ser = m_sr[7];
        e.chk_par = chk_par;
        q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    task automatic shift_bit(input logic b);
        @(posedge clk); ser_in = b;
        @(negedge clk); shift_clk = 1'b1;
        if (clr_n) m_sr = {m_sr[6:0], b};
        @(negedge clk); shift_clk = 1'b0;
    endtask

    task automatic store_pulse();
        @(negedge clk); store_clk = 1'b1; m_st = m_sr;
        @(negedge clk); store_clk = 1'b0;
    endtask

    task automatic both_edges(input logic b);
        @(posedge clk); ser_in = b;
        @(negedge clk); shift_clk = 1'b1; store_clk = 1'b1;
        m_st = m_sr; m_sr = {m_sr[6:0], b};
        @(negedge clk); shift_clk = 1'b0; store_clk = 1'b0;
    endtask

    task automatic clear_pulse();
        @(negedge clk); clr_n = 1'b0; m_sr = 8'h00;
        @(negedge clk); clr_n = 1'b1;
    endtask

    task automatic set_oe(input logic v);
        @(negedge clk); oe_n = v;
    endtask

    task automatic load_byte(input logic [7:0] v, input string tag);
        for (int i = 7; i >= 0; i--) begin
            shift_bit(v[i]);
            expect_now(tag, 1'b1);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000 && !done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // reset state: clear, outputs floating
        clear_pulse();
        expect_now("R4 clear state", 1'b1);
        expect_now("R6 disabled floats", 1'b1);
        // R8: transfer after clear gives zeros
        store_pulse();
        set_oe(1'b0);
        expect_now("R8 zero transfer", 1'b1);
        // R2 R7 R1: shift A5 while enabled; pins hold, cascade follows stage 7
        load_byte(8'hA5, "R1 R7 shift A5");
        store_pulse();
        expect_now("R5 R2 transfer A5", 1'b1);
        // R6: disable then enable
        set_oe(1'b1);
        expect_now("R6 disable", 1'b1);
        shift_bit(1'b1);
        expect_now("R7 cascade while disabled", 1'b1);
        set_oe(1'b0);
        expect_now("R6 enable", 1'b1);
        // R8: clear keeps storage
        clear_pulse();
        expect_now("R8 clear keeps storage", 1'b1);
        store_pulse();
        expect_now("R8 store after clear", 1'b1);
        // R3: wiggle ser_in without shift edges
        load_byte(8'h3C, "R2 shift 3C");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); ser_in = i[0];
        end
        expect_now("R3 hold without edge", 1'b1);
        store_pulse();
        expect_now("R3 R5 transfer 3C", 1'b1);
        // R9: coincident edges
        both_edges(1'b1);
        expect_now("R9 coincident capture", 1'b1);
        store_pulse();
        expect_now("R9 later transfer", 1'b1);
        // R4: clear held low over shift edges with ser_in high
        @(negedge clk); clr_n = 1'b0; m_sr = 8'h00;
        for (int i = 0; i < 3; i++) shift_bit(1'b1);
        expect_now("R4 clear dominates", 1'b1);
        store_pulse();
        expect_now("R4 zeros stored", 1'b1);
        // R10: release without clock, then one shift
        @(negedge clk); clr_n = 1'b1;
        shift_bit(1'b1);
        store_pulse();
        expect_now("R10 shift after release", 1'b1);
        // R2: second pattern with distinct bits
        load_byte(8'hC3, "R2 shift C3");
        store_pulse();
        expect_now("R2 transfer C3", 1'b1);
        @(posedge clk); #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule